// File: doc/BRIEF.md
# ADC Status Flag Register

This block holds the six sticky event flags of an analog-to-digital converter controller and presents them as one 32-bit word on a simple register bus. The conversion engine, sequencer, watchdog comparators and result register live elsewhere. They reach this block only as one-cycle strobes.

A strobe raises its flag in the next cycle. The flag stays raised until software writes a zero to its bit, using a full-word write. The regular end-of-conversion flag is also dropped when the result register is read. The flag's source depends on a mode input: it follows every single conversion, or only the end of a whole regular sequence. Overrun is derived inside the block: a regular result arrives while the end-of-conversion flag from the previous result is still set. It is only recorded when DMA mode or per-sequence mode is active.

An interrupt request is raised whenever any flag is set.

Top module: `adc_flag_reg`

## Requirements
- R1: After reset every flag reads 0, `bus_rdata_o` is 0 and `irq_o` is 0.
- R2: Each flag appears at a fixed bit, one cycle after its strobe. The bits are: watchdog hit bit 0, regular end of conversion bit 1, injected group done bit 2, injected start bit 3, regular start bit 4, overrun bit 5.
- R3: A write with all four byte enables set clears every flag whose `bus_wdata_i` bit is 0. Flags whose data bit is 1 are left unchanged.
- R4: A write with any byte enable pattern other than 4'b1111 changes no flag.
- R5: A `dr_read_i` strobe clears the regular end-of-conversion flag (bit 1) and no other flag.
- R6: With `eoc_per_seq_i` = 0, bit 1 is set by `conv_done_i` and not by `seq_done_i`. With `eoc_per_seq_i` = 1, bit 1 is set only by `seq_done_i`.
- R7: Bit 5 sets when `conv_done_i` arrives while bit 1 is already set and `dma_mode_i` or `eoc_per_seq_i` is 1. When both mode inputs are 0 the condition is ignored.
- R8: If a set strobe and a clear hit the same flag in one cycle, the flag ends set. The clear may come from a bus write or from `dr_read_i`.
- R9: A read (`bus_sel_i`=1, `bus_wr_i`=0) returns its data on `bus_rdata_o` in the following cycle. Byte lanes whose enable is 0 read as zero, and bits 31:6 always read as zero.
- R10: `irq_o` is 1 exactly when at least one flag is set. It changes in the same cycle as the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wdog_hit_i | input | 1 | Watchdog threshold crossing strobe |
| conv_done_i | input | 1 | One regular conversion completed |
| seq_done_i | input | 1 | Whole regular sequence completed |
| inj_done_i | input | 1 | All injected channels converted |
| inj_start_i | input | 1 | Injected group conversion started |
| reg_start_i | input | 1 | Regular conversion started |
| dma_mode_i | input | 1 | DMA mode active (enables overrun detection) |
| eoc_per_seq_i | input | 1 | End-of-conversion flag per sequence (1) or per conversion (0) |
| dr_read_i | input | 1 | Result register read strobe |
| bus_sel_i | input | 1 | Register access this cycle |
| bus_wr_i | input | 1 | Access is a write |
| bus_be_i | input | DATA_W/8 | Byte lane enables |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Any flag set |

## Verification
Every flag moves on the first clock edge after the strobe, write or result-register read that affects it. A read issued in the following cycle therefore sees the new value. Read data is registered, so it is valid one cycle after the read. The bench drives and releases every input on the falling edge, one full cycle per action. It samples `bus_rdata_o` and `irq_o` on the falling edge after the read's rising edge, which means each flag update is checked exactly two rising edges after its cause. Coincident set-and-clear cases are driven within a single cycle, so the priority rule is exercised on the same edge.

// File: rtl/adc_flag_pkg.sv
package adc_flag_pkg;
  localparam int NUM_FLAGS  = 6;
  // bit positions inside the status word
  localparam int IDX_WDOG   = 0;
  localparam int IDX_EOC    = 1;
  localparam int IDX_JEOC   = 2;
  localparam int IDX_JSTART = 3;
  localparam int IDX_RSTART = 4;
  localparam int IDX_OVR    = 5;
endpackage

// File: rtl/adc_flag_evt.sv
module adc_flag_evt
  import adc_flag_pkg::*;
(
  input  logic                 wdog_hit_i,
  input  logic                 conv_done_i,
  input  logic                 seq_done_i,
  input  logic                 inj_done_i,
  input  logic                 inj_start_i,
  input  logic                 reg_start_i,
  input  logic                 dma_mode_i,
  input  logic                 eoc_per_seq_i,
  input  logic                 eoc_flag_i,
  output logic [NUM_FLAGS-1:0] set_o
);
  logic ovr_armed;
  assign ovr_armed = dma_mode_i | eoc_per_seq_i;

  always_comb begin
    set_o             = '0;
    set_o[IDX_WDOG]   = wdog_hit_i;
    set_o[IDX_EOC]    = eoc_per_seq_i ? seq_done_i : conv_done_i;
    set_o[IDX_JEOC]   = inj_done_i;
    set_o[IDX_JSTART] = inj_start_i;
    set_o[IDX_RSTART] = reg_start_i;
    // a fresh result lands while the previous one is still unacknowledged
    set_o[IDX_OVR]    = conv_done_i & eoc_flag_i & ovr_armed;
  end
endmodule

// File: rtl/adc_flag_cell.sv
module adc_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  // R8: a hardware event beats any clear in the same cycle
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q_o);
  // R3 / R5: a clear with no competing event drops the flag
  a_r3_clear_takes: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/adc_flag_rd.sv
module adc_flag_rd
  import adc_flag_pkg::*;
#(
  parameter  int DATA_W = 32,
  localparam int BE_W   = DATA_W/8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en_i,
  input  logic [BE_W-1:0]      be_i,
  input  logic [NUM_FLAGS-1:0] flags_i,
  output logic [DATA_W-1:0]    rdata_o
);
  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] lane_mask;

  assign word = DATA_W'(flags_i);

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign lane_mask[g*8 +: 8] = {8{be_i[g]}};
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_o <= '0;
    else if (rd_en_i) rdata_o <= word & lane_mask;
    else              rdata_o <= '0;
  end

  // R9: reserved bits never carry data
  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    rdata_o[DATA_W-1:NUM_FLAGS] == '0);
endmodule

// File: rtl/adc_flag_reg.sv
module adc_flag_reg
  import adc_flag_pkg::*;
#(
  parameter  int DATA_W = 32,
  localparam int BE_W   = DATA_W/8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wdog_hit_i,
  input  logic              conv_done_i,
  input  logic              seq_done_i,
  input  logic              inj_done_i,
  input  logic              inj_start_i,
  input  logic              reg_start_i,
  input  logic              dma_mode_i,
  input  logic              eoc_per_seq_i,
  input  logic              dr_read_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [BE_W-1:0]   bus_be_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  logic [NUM_FLAGS-1:0] flag_q;
  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_FLAGS-1:0] clr_vec;
  logic                 full_wr;
  logic                 rd_en;
  logic                 unused_wdata;

  assign full_wr      = bus_sel_i & bus_wr_i & (&bus_be_i);
  assign rd_en        = bus_sel_i & ~bus_wr_i;
  assign unused_wdata = ^bus_wdata_i[DATA_W-1:NUM_FLAGS];

  adc_flag_evt u_evt (
    .wdog_hit_i    (wdog_hit_i),
    .conv_done_i   (conv_done_i),
    .seq_done_i    (seq_done_i),
    .inj_done_i    (inj_done_i),
    .inj_start_i   (inj_start_i),
    .reg_start_i   (reg_start_i),
    .dma_mode_i    (dma_mode_i),
    .eoc_per_seq_i (eoc_per_seq_i),
    .eoc_flag_i    (flag_q[IDX_EOC]),
    .set_o         (set_vec)
  );

  always_comb begin
    clr_vec          = {NUM_FLAGS{full_wr}} & ~bus_wdata_i[NUM_FLAGS-1:0];
    clr_vec[IDX_EOC] = clr_vec[IDX_EOC] | dr_read_i;
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    adc_flag_cell u_cell (
      .clk   (clk),
      .rst   (rst),
      .set_i (set_vec[i]),
      .clr_i (clr_vec[i]),
      .q_o   (flag_q[i])
    );
  end

  adc_flag_rd #(.DATA_W(DATA_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en_i (rd_en),
    .be_i    (bus_be_i),
    .flags_i (flag_q),
    .rdata_o (bus_rdata_o)
  );

  assign irq_o = |flag_q;

  // R1: synchronous reset empties the register and the read path
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (flag_q == '0 && bus_rdata_o == '0));
  // R4: a partial-lane write with nothing else going on leaves all flags alone
  a_r4_partial_write: assert property (@(posedge clk) disable iff (rst)
    (bus_sel_i && bus_wr_i && !(&bus_be_i) && set_vec == '0 && !dr_read_i)
      |=> flag_q == $past(flag_q));
  // R7: with both mode inputs low an overrun never appears
  a_r7_ovr_gated: assert property (@(posedge clk) disable iff (rst)
    (!dma_mode_i && !eoc_per_seq_i && !flag_q[IDX_OVR]) |=> !flag_q[IDX_OVR]);
  // R5: a result read with no new event leaves only bit 1 dropped, others held
  a_r5_drread_scope: assert property (@(posedge clk) disable iff (rst)
    (dr_read_i && !bus_sel_i && set_vec == '0)
      |=> (!flag_q[IDX_EOC] && flag_q[0] == $past(flag_q[0])
           && flag_q[NUM_FLAGS-1:2] == $past(flag_q[NUM_FLAGS-1:2])));
endmodule

// File: tb/tb_adc_flag_reg.sv
module tb_adc_flag_reg;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 32;
  localparam int BE_W       = DATA_W/8;

  logic clk = 1'b0;
  logic rst;
  logic wdog_hit_i, conv_done_i, seq_done_i, inj_done_i, inj_start_i, reg_start_i;
  logic dma_mode_i, eoc_per_seq_i, dr_read_i;
  logic bus_sel_i, bus_wr_i;
  logic [BE_W-1:0]   bus_be_i;
  logic [DATA_W-1:0] bus_wdata_i;
  logic [DATA_W-1:0] bus_rdata_o;
  logic irq_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_flag_reg #(.DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst),
    .wdog_hit_i(wdog_hit_i), .conv_done_i(conv_done_i), .seq_done_i(seq_done_i),
    .inj_done_i(inj_done_i), .inj_start_i(inj_start_i), .reg_start_i(reg_start_i),
    .dma_mode_i(dma_mode_i), .eoc_per_seq_i(eoc_per_seq_i), .dr_read_i(dr_read_i),
    .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i), .bus_be_i(bus_be_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
  );

  task automatic idle_inputs();
    wdog_hit_i = 0; conv_done_i = 0; seq_done_i = 0; inj_done_i = 0;
    inj_start_i = 0; reg_start_i = 0; dr_read_i = 0;
    bus_sel_i = 0; bus_wr_i = 0; bus_be_i = '0; bus_wdata_i = '0;
  endtask

  // one clock: inputs set before the call are applied on the rising edge
  task automatic step();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic check(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic read_word(input logic [BE_W-1:0] be, output logic [DATA_W-1:0] val);
    bus_sel_i = 1; bus_wr_i = 0; bus_be_i = be;
    step();
    val = bus_rdata_o;
  endtask

  task automatic write_word(input logic [BE_W-1:0] be, input logic [DATA_W-1:0] d);
    bus_sel_i = 1; bus_wr_i = 1; bus_be_i = be; bus_wdata_i = d;
    step();
  endtask

  task automatic expect_flags(string req, logic [DATA_W-1:0] exp);
    logic [DATA_W-1:0] v;
    read_word(4'hF, v);
    check(req, v, exp);
  endtask

  task automatic clear_all();
    write_word(4'hF, '0);
  endtask

  task automatic t_reset();
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    check("R1 rdata", bus_rdata_o, 32'h0);
    expect_flags("R1 flags", 32'h0);
  endtask

  task automatic t_bit_map();
    wdog_hit_i = 1;  step(); expect_flags("R2 wdog bit0", 32'h01);
    check("R10 irq set", {31'b0, irq_o}, 32'h1);
    conv_done_i = 1; step(); expect_flags("R2 eoc bit1", 32'h03);
    inj_done_i = 1;  step(); expect_flags("R2 jeoc bit2", 32'h07);
    inj_start_i = 1; step(); expect_flags("R2 jstart bit3", 32'h0F);
    reg_start_i = 1; step(); expect_flags("R2 rstart bit4", 32'h1F);
    clear_all();     expect_flags("R3 clear all", 32'h0);
    check("R10 irq clear", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_write_one();
    wdog_hit_i = 1; inj_done_i = 1; reg_start_i = 1; step();
    write_word(4'hF, 32'hFFFF_FFFF);
    expect_flags("R3 write ones keep", 32'h15);
    write_word(4'hF, 32'hFFFF_FFFE);
    expect_flags("R3 clear bit0 only", 32'h14);
    clear_all();
  endtask

  task automatic t_partial();
    wdog_hit_i = 1; inj_start_i = 1; step();
    write_word(4'h7, '0);
    expect_flags("R4 be 0111 ignored", 32'h09);
    write_word(4'h1, '0);
    expect_flags("R4 be 0001 ignored", 32'h09);
    clear_all();
  endtask

  task automatic t_drread();
    wdog_hit_i = 1; conv_done_i = 1; inj_done_i = 1; step();
    dr_read_i = 1; step();
    expect_flags("R5 dr read clears eoc only", 32'h05);
    clear_all();
  endtask

  task automatic t_eocs();
    eoc_per_seq_i = 1;
    conv_done_i = 1; step(); expect_flags("R6 eocs1 single ignored", 32'h0);
    seq_done_i = 1;  step(); expect_flags("R6 eocs1 seq sets", 32'h02);
    clear_all();
    eoc_per_seq_i = 0;
    seq_done_i = 1;  step(); expect_flags("R6 eocs0 seq ignored", 32'h0);
  endtask

  task automatic t_ovr();
    dma_mode_i = 0; eoc_per_seq_i = 0;
    conv_done_i = 1; step();
    conv_done_i = 1; step(); expect_flags("R7 gated off", 32'h02);
    dma_mode_i = 1;
    conv_done_i = 1; step(); expect_flags("R7 dma overrun", 32'h22);
    clear_all();
    conv_done_i = 1; step(); expect_flags("R7 no prior eoc", 32'h02);
    clear_all();
    dma_mode_i = 0; eoc_per_seq_i = 1;
    seq_done_i = 1; step();
    conv_done_i = 1; step(); expect_flags("R7 eocs overrun", 32'h22);
    eoc_per_seq_i = 0;
    clear_all();
  endtask

  task automatic t_set_wins();
    wdog_hit_i = 1; bus_sel_i = 1; bus_wr_i = 1; bus_be_i = 4'hF; bus_wdata_i = '0;
    step(); expect_flags("R8 set beats write clear", 32'h01);
    clear_all();
    conv_done_i = 1; step();
    conv_done_i = 1; dr_read_i = 1; step();
    expect_flags("R8 set beats dr read", 32'h02);
    clear_all();
  endtask

  task automatic t_byte_read();
    logic [DATA_W-1:0] v;
    wdog_hit_i = 1; reg_start_i = 1; step();
    read_word(4'h1, v); check("R9 lane0 read", v, 32'h11);
    read_word(4'hE, v); check("R9 lane0 off", v, 32'h0);
    read_word(4'h3, v); check("R9 half read", v, 32'h11);
    check("R9 data one cycle only", bus_rdata_o, 32'h11);
    step(); check("R9 idle returns zero", bus_rdata_o, 32'h0);
    clear_all();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    dma_mode_i = 0; eoc_per_seq_i = 0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_bit_map();
    t_write_one();
    t_partial();
    t_drread();
    t_eocs();
    t_ovr();
    t_set_wins();
    t_byte_read();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule